// File: doc/BRIEF.md
# Serial Peripheral Master with Nine-Bit Command Framing

This block is a single-channel serial peripheral master. A host loads one word, sets a few configuration inputs and pulses `start`. The block then drives a serial clock derived from the core clock, shifts the word out most significant bit first and samples the returning line. When the last clock edge is done, it reports the received byte. Three framings are offered: a four-wire full-duplex byte, a half-duplex byte on one shared data wire, and a nine-bit frame for display controllers. In the nine-bit frame a leading flag marks the byte as a command or as data.

The serial clock rate comes from a divider input. The divider is forced even, and a value that leaves zero after rounding means the largest divisor. Clock idle level, clock phase and chip-select polarity are inputs. One of up to `NUM_CS` select lines is driven while a transfer runs, or none at all for a bus with one device.

Top module: `spi_lossi_master`

## Requirements
- R1: After reset, `busy`, `done`, `mosi_o`, `mosi_oe_n` and `rx_word` are 0. `sclk` equals `cfg_cpol`, and every `cs_o` line is at its inactive level.
- R2: The effective divisor D is `cfg_div` with bit 0 cleared, and 2^DIV_W when that result is 0. Each serial clock half period lasts D/2 core cycles. The first edge comes D/2 cycles after the cycle that accepted `start`.
- R3: While idle, `sclk` equals `cfg_cpol`. With `cfg_cpha`=0 the line is sampled on leading edges (odd edges) and the output bit changes on trailing edges. With `cfg_cpha`=1 the output changes on leading edges other than the first and is sampled on trailing edges. The first bit is on `mosi_o` from the start of the transfer.
- R4: In mode 00 (and 11), a frame is 8 bits of `tx_word`, MSB first, on `mosi_o`. `miso` is sampled and the 8 sampled bits form `rx_word`, first sample in bit 7.
- R5: In mode 10, a frame is 9 bits. The first bit is `cfg_lossi_data` (1 = data or parameter byte, 0 = command byte), followed by `tx_word` MSB first. `rx_word` holds the last 8 of the 9 sampled bits.
- R6: In mode 01 with `cfg_rx_dir`=1 (receive), `mosi_oe_n` is 1 for the whole transfer and `mosi_o` is 0. The shared line `mosi_i` is sampled and `miso` has no effect on `rx_word`.
- R7: In mode 01 with `cfg_rx_dir`=0 (transmit), `mosi_oe_n` stays 0, the 8 bits go out on `mosi_o`, and `rx_word` keeps its previous value.
- R8: While busy, only `cs_o[cfg_cs_sel]` is at its active level. That level is `cfg_cs_high` (0 = active low). The other lines stay inactive, and with `cfg_no_cs`=1 all lines stay inactive.
- R9: `busy` rises in the cycle after `start` is accepted and falls together with the 2N-th clock edge (N = frame bits). `done` is high for exactly that one cycle, and `rx_word` is updated with it and held until the next update.
- R10: A `start` pulse while `busy` is high has no effect on the ongoing frame or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 00 standard, 01 shared wire, 10 nine-bit, 11 standard |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase |
| cfg_cs_high | input | 1 | 1 = select lines active high |
| cfg_no_cs | input | 1 | 1 = drive no select line |
| cfg_div | input | DIV_W | Clock divider value |
| cfg_cs_sel | input | SEL_W | Index of the select line to drive |
| cfg_rx_dir | input | 1 | Shared-wire direction: 1 receive, 0 transmit |
| cfg_lossi_data | input | 1 | Nine-bit flag: 1 data, 0 command |
| start | input | 1 | Begin a transfer when idle |
| tx_word | input | 8 | Byte to send |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_word | output | 8 | Last received byte |
| sclk | output | 1 | Serial clock |
| mosi_o | output | 1 | Outgoing data, also the shared wire's drive value |
| mosi_oe_n | output | 1 | 1 = release the shared wire driver |
| mosi_i | input | 1 | Value read back from the shared wire |
| miso | input | 1 | Incoming data in four-wire framings |
| cs_o | output | NUM_CS | Device select lines |

## Verification
Standard frames are run in all four clock-polarity and phase combinations, each with a different divider. This separates a wrong sampling edge, a wrong shift edge and a wrong half-period length, because every pair of the four gives a different waveform. Nine-bit frames are sent both as a command and as data, so a fixed or inverted flag bit shows up on the wire. The shared-wire mode drives `miso` with the complement of `mosi_i` while receiving, which exposes a receiver that samples the wrong pin. A transmit follows, and `rx_word` must keep its old value through it. Divider values 0 and 1 check the wrap to the largest divisor. A second start inside a running frame must leave that frame unchanged.

// File: rtl/spi_lossi_master.sv
module spi_lossi_master #(
  parameter int NUM_CS = 3,
  parameter int DIV_W  = 16,
  parameter int SEL_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_cs_high,
  input  logic             cfg_no_cs,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [SEL_W-1:0] cfg_cs_sel,
  input  logic             cfg_rx_dir,
  input  logic             cfg_lossi_data,
  input  logic             start,
  input  logic [7:0]       tx_word,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rx_word,
  output logic             sclk,
  output logic             mosi_o,
  output logic             mosi_oe_n,
  input  logic             mosi_i,
  input  logic             miso,
  output logic [NUM_CS-1:0] cs_o
);

  localparam logic [1:0] M_BIDIR = 2'b01;
  localparam logic [1:0] M_LOSSI = 2'b10;
  localparam logic [DIV_W-1:0] HALF_MAX = {1'b1, {(DIV_W-1){1'b0}}};

  logic             busy_r, done_r, sclk_r, cpha_l, rx_dir_l;
  logic [1:0]       mode_l;
  logic [SEL_W-1:0] sel_l;
  logic [DIV_W-1:0] half_l, cnt;
  logic [4:0]       edge_cnt;
  logic [3:0]       nbits_l;
  logic [8:0]       sh_tx;
  logic [7:0]       sh_rx, rx_r;

  wire [DIV_W-1:0] half_raw = cfg_div >> 1;
  wire [DIV_W-1:0] half_new = (half_raw == '0) ? HALF_MAX : half_raw;

  wire       tick      = busy_r && (cnt == half_l - 1'b1);
  wire [4:0] edge_no   = edge_cnt + 5'd1;
  wire       leading   = edge_no[0];
  wire       last      = (edge_no == {nbits_l, 1'b0});
  wire       bidir_l   = (mode_l == M_BIDIR);
  wire       rx_on     = !bidir_l || rx_dir_l;
  wire       in_bit    = bidir_l ? mosi_i : miso;
  wire       do_sample = tick && (cpha_l ? !leading : leading);
  wire       do_shift  = tick && (cpha_l ? (leading && edge_cnt != 5'd0) : !leading);
  wire [7:0] rx_next   = do_sample ? {sh_rx[6:0], in_bit} : sh_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_r   <= 1'b0;
      done_r   <= 1'b0;
      sclk_r   <= 1'b0;
      cpha_l   <= 1'b0;
      rx_dir_l <= 1'b0;
      mode_l   <= 2'b00;
      sel_l    <= '0;
      half_l   <= HALF_MAX;
      cnt      <= '0;
      edge_cnt <= '0;
      nbits_l  <= 4'd8;
      sh_tx    <= '0;
      sh_rx    <= '0;
      rx_r     <= '0;
    end else begin
      done_r <= 1'b0;
      if (!busy_r) begin
        if (start) begin
          busy_r   <= 1'b1;
          mode_l   <= cfg_mode;
          cpha_l   <= cfg_cpha;
          rx_dir_l <= cfg_rx_dir;
          sel_l    <= cfg_cs_sel;
          half_l   <= half_new;
          cnt      <= '0;
          edge_cnt <= '0;
          sclk_r   <= cfg_cpol;
          sh_rx    <= '0;
          sh_tx    <= (cfg_mode == M_LOSSI) ? {cfg_lossi_data, tx_word} : {tx_word, 1'b0};
          nbits_l  <= (cfg_mode == M_LOSSI) ? 4'd9 : 4'd8;
        end
      end else if (tick) begin
        cnt      <= '0;
        edge_cnt <= edge_no;
        sclk_r   <= ~sclk_r;
        sh_rx    <= rx_next;
        if (do_shift) sh_tx <= {sh_tx[7:0], 1'b0};
        if (last) begin
          busy_r <= 1'b0;
          done_r <= 1'b1;
          if (rx_on) rx_r <= rx_next;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign busy      = busy_r;
  assign done      = done_r;
  assign rx_word   = rx_r;
  assign sclk      = busy_r ? sclk_r : cfg_cpol;
  assign mosi_oe_n = busy_r && bidir_l && rx_dir_l;
  assign mosi_o    = busy_r && !mosi_oe_n && sh_tx[8];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_o[i] = (busy_r && !cfg_no_cs && sel_l == SEL_W'(i)) ? cfg_cs_high : ~cfg_cs_high;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done_r |=> !done_r); // R9
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_r) |-> done_r); // R9
  AST_EDGE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_r) |-> edge_cnt == {nbits_l, 1'b0}); // R9
  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (busy_r && !tick) |=> $stable(sclk_r)); // R2
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) busy_r |-> cnt < half_l); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy_r && start && !tick) |=> $stable(sh_tx) && $stable(half_l)); // R10

endmodule

// File: tb/tb_spi_lossi_master.sv
module tb_spi_lossi_master;
  localparam int NUM_CS = 3;
  localparam int DIV_W  = 8;
  localparam int SEL_W  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] cfg_mode = 0;
  logic cfg_cpol = 0, cfg_cpha = 0, cfg_cs_high = 0, cfg_no_cs = 0, cfg_rx_dir = 0, cfg_lossi_data = 0;
  logic [DIV_W-1:0] cfg_div = 2;
  logic [SEL_W-1:0] cfg_cs_sel = 0;
  logic start = 0;
  logic [7:0] tx_word = 0;
  logic busy, done, sclk, mosi_o, mosi_oe_n;
  logic mosi_i = 0, miso = 0;
  logic [7:0] rx_word;
  logic [NUM_CS-1:0] cs_o;

  spi_lossi_master #(.NUM_CS(NUM_CS), .DIV_W(DIV_W), .SEL_W(SEL_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_cs_high(cfg_cs_high), .cfg_no_cs(cfg_no_cs), .cfg_div(cfg_div), .cfg_cs_sel(cfg_cs_sel),
    .cfg_rx_dir(cfg_rx_dir), .cfg_lossi_data(cfg_lossi_data), .start(start), .tx_word(tx_word),
    .busy(busy), .done(done), .rx_word(rx_word), .sclk(sclk), .mosi_o(mosi_o),
    .mosi_oe_n(mosi_oe_n), .mosi_i(mosi_i), .miso(miso), .cs_o(cs_o));

  int total = 0, bad = 0, wd = 0;
  int pat = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model and slave
  int m_busy = 0, m_done = 0, m_sclk = 0, m_cnt = 0, m_h = 1, m_k = 0, m_j = 0, m_n = 8;
  int m_cpha = 0, m_mode = 0, m_rxdir = 0, m_sel = 0, m_frame = 0, m_acc = 0, m_rx = 0, m_pat = 0;
  always @(posedge clk) begin
    int lead, line;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_rx = 0;
      miso <= 0; mosi_i <= 0;
    end else begin
      m_done = 0;
      if (m_busy == 0) begin
        if (start) begin
          m_busy = 1; m_cnt = 0; m_k = 0; m_j = 0; m_acc = 0;
          m_mode = cfg_mode; m_cpha = cfg_cpha; m_rxdir = cfg_rx_dir; m_sel = cfg_cs_sel;
          m_sclk = cfg_cpol; m_pat = pat;
          m_h = ((cfg_div >> 1) == 0) ? (1 << (DIV_W - 1)) : (cfg_div >> 1);
          m_n = (cfg_mode == 2) ? 9 : 8;
          m_frame = (cfg_mode == 2) ? (int'(cfg_lossi_data) * 256 + tx_word) : tx_word;
        end
      end else begin
        m_cnt++;
        if (m_cnt == m_h) begin
          m_cnt = 0; m_k++; m_sclk = !m_sclk;
          lead = m_k % 2;
          line = (m_pat >> (m_n - 1 - m_j)) & 1;
          if (m_cpha ? !lead : lead) m_acc = m_acc * 2 + line;
          if (m_cpha ? (lead && m_k > 1) : !lead) m_j++;
          if (m_k == 2 * m_n) begin
            m_busy = 0; m_done = 1;
            if (m_mode != 1 || m_rxdir) m_rx = m_acc & 255;
          end
        end
      end
      line = m_busy ? ((m_pat >> (m_n - 1 - m_j)) & 1) : 0;
      if (m_mode == 1 && m_busy) begin
        mosi_i <= line[0]; miso <= ~line[0];
      end else begin
        mosi_i <= 1'b0; miso <= line[0];
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      int e_sclk, e_oe, e_mosi, e_cs;
      string mreq;
      e_sclk = m_busy ? m_sclk : cfg_cpol;
      e_oe = (m_busy && m_mode == 1 && m_rxdir) ? 1 : 0;
      e_mosi = (m_busy && !e_oe) ? ((m_frame >> (m_n - 1 - m_j)) & 1) : 0;
      e_cs = 0;
      for (int i = 0; i < NUM_CS; i++)
        e_cs |= ((m_busy && !cfg_no_cs && m_sel == i) ? int'(cfg_cs_high) : int'(!cfg_cs_high)) << i;
      mreq = (m_mode == 2) ? "R5" : (m_mode == 1) ? "R7" : "R4";
      chk(busy == m_busy[0], "R9", "busy", busy, m_busy);
      chk(done == m_done[0], "R9", "done", done, m_done);
      chk(sclk == e_sclk[0], "R2/R3", "sclk", sclk, e_sclk);
      chk(mosi_o == e_mosi[0], mreq, "mosi_o", mosi_o, e_mosi);
      chk(mosi_oe_n == e_oe[0], "R6", "mosi_oe_n", mosi_oe_n, e_oe);
      chk(cs_o == e_cs[NUM_CS-1:0], "R8", "cs_o", cs_o, e_cs);
      chk(rx_word == m_rx[7:0], "R9", "rx_word", rx_word, m_rx);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      bad++; total++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", wd, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(input int mode, input int cpol, input int cpha, input int div, input int sel,
                     input int csh, input int nocs, input int dir, input int typ, input int tx,
                     input int p, input int exp_rx, input int n, input int h, input string req,
                     input bit poke);
    int cyc, tog;
    logic prev;
    @(negedge clk);
    cfg_mode = mode[1:0]; cfg_cpol = cpol[0]; cfg_cpha = cpha[0]; cfg_div = div[DIV_W-1:0];
    cfg_cs_sel = sel[SEL_W-1:0]; cfg_cs_high = csh[0]; cfg_no_cs = nocs[0]; cfg_rx_dir = dir[0];
    cfg_lossi_data = typ[0]; tx_word = tx[7:0]; pat = p;
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    cyc = 1; tog = 0; prev = sclk;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (sclk != prev) tog++;
      prev = sclk;
      if (poke && cyc == 3) begin start = 1; tx_word = ~tx[7:0]; cfg_div = 2; end
      else start = 0;
    end
    chk(cyc == 2 * n * h + 1, "R2", "transfer cycles", cyc, 2 * n * h + 1);
    chk(tog == 2 * n, "R9", "clock edges", tog, 2 * n);
    chk(rx_word == exp_rx[7:0], req, "received byte", rx_word, exp_rx);
    if (poke) chk(rx_word == exp_rx[7:0], "R10", "result after extra start", rx_word, exp_rx);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(busy == 0 && done == 0, "R1", "busy/done in reset", {busy, done}, 0);
    chk(sclk == 0, "R1", "sclk in reset", sclk, 0);
    chk(cs_o == 3'b111, "R1", "cs in reset", cs_o, 7);
    chk(mosi_o == 0 && mosi_oe_n == 0, "R1", "data pins in reset", {mosi_o, mosi_oe_n}, 0);
    chk(rx_word == 0, "R1", "rx_word in reset", rx_word, 0);
    rst_n = 1;
    @(negedge clk);
    //  mode cpol cpha div sel csh nocs dir typ tx    pat    exp   n  h
    run(0, 0, 0, 2, 0, 0, 0, 0, 0, 'hA5, 'h3C, 'h3C, 8, 1, "R4", 0);
    run(0, 1, 1, 5, 2, 1, 0, 0, 0, 'h81, 'h7E, 'h7E, 8, 2, "R3", 0);
    run(0, 0, 1, 6, 1, 0, 0, 0, 0, 'h0F, 'hC1, 'hC1, 8, 3, "R3", 0);
    run(3, 1, 0, 3, 0, 0, 0, 0, 0, 'hF0, 'h96, 'h96, 8, 1, "R4", 1);
    run(2, 0, 0, 4, 1, 0, 0, 0, 0, 'h2A, 'h1B5, 'hB5, 9, 2, "R5", 0);
    run(2, 0, 1, 2, 0, 0, 0, 0, 1, 'h55, 'h0AA, 'hAA, 9, 1, "R5", 0);
    run(1, 0, 0, 4, 2, 0, 0, 1, 0, 'hFF, 'hC3, 'hC3, 8, 2, "R6", 0);
    run(1, 1, 0, 2, 0, 0, 0, 0, 0, 'h5A, 'h00, 'hC3, 8, 1, "R7", 0);
    run(0, 0, 0, 2, 1, 0, 1, 0, 0, 'h11, 'h22, 'h22, 8, 1, "R8", 0);
    run(0, 0, 0, 0, 0, 0, 0, 0, 0, 'h3C, 'h99, 'h99, 8, 128, "R2", 0);
    run(0, 1, 0, 1, 2, 1, 0, 0, 0, 'hC3, 'h66, 'h66, 8, 128, "R2", 0);
    repeat (3) @(negedge clk);
    chk(busy == 0 && cs_o == 3'b000, "R8", "idle select level, active high", cs_o, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule